// File: doc/BRIEF.md
# Streaming Parallel CRC Frame Checker

This block checks frames that arrive as a stream of `SAMPLE_W`-bit samples, framed by start, end and valid strobes. The last `CRC_W` bits of every frame are a received checksum. The block folds `SAMPLE_W` message bits into a `CRC_W`-bit remainder on each accepted sample. At the end of the frame it compares the finished checksum with the received one and flags a mismatch. The message samples leave the block with their own start, end and valid strobes. The checksum samples are removed, so downstream logic sees only the payload, with a verdict attached to its last sample.

The generator polynomial, seed, direct or nondirect (zero-augmented) calculation, per-byte bit reversal of the input and of the checksum, and the final XOR value are all parameters. `CRC_W` must be a whole multiple of `SAMPLE_W`. Let K = `CRC_W`/`SAMPLE_W`; this is the number of checksum samples. The block holds back K valid samples in a window. A sample is treated as message only once K further valid samples of the same frame have followed it.

The control is a three-state machine:
- **IDLE**: no frame is open.
- **FILL**: the window holds fewer than K samples of the open frame.
- **RUN**: the window is full, and every further valid sample pushes the oldest one out as message.

The transitions are:
- **start**: a valid start strobe, taken from any state, goes to FILL (RUN when K is 1). It goes to IDLE when the same sample also ends the frame.
- **filled**: the K-th sample of the frame moves FILL to RUN.
- **short end**: an end strobe in FILL returns to IDLE with no output.
- **frame end**: an end strobe in RUN returns to IDLE and emits the verdict.

Top module: `crc_frame_checker`

## Requirements
- R1: While reset is active, and afterwards until a frame is processed, `out_valid`, `out_sof`, `out_eof` and `out_err` are low.
- R2: A message sample is emitted unchanged on `out_data`, with `out_valid` high, one clock after the input sample that arrives K valid samples after it in the same frame. Message samples leave in arrival order.
- R3: The last K valid samples of a frame are never emitted. They form the received checksum, with the first of them as the most significant `SAMPLE_W` bits.
- R4: `out_sof` marks the first emitted sample of a frame and `out_eof` marks its last message sample. The clock after `out_eof` never has `out_valid` high.
- R5: With the default parameters (polynomial 0x1021 of degree 16, seed 0xFFFF, direct, no reflection, final XOR 0, 8-bit samples processed MSB first), `out_err` is 0 when the received checksum equals the CRC of the message. For example, ASCII "123456789" has checksum 0x29B1. `out_err` is 1 when any message or checksum bit is corrupted.
- R6: `out_err` is only ever high together with `out_eof`.
- R7: Cycles with `in_valid` low change neither the checksum nor the window. The cycle after such a cycle has `out_valid` low.
- R8: A valid start strobe during an open frame abandons that frame, which then gets no `out_eof` and no verdict. The new frame is checked from the seed.
- R9: A frame of K or fewer valid samples produces no output at all.
- R10: `out_sof` and `out_eof` are only ever high together with `out_valid`.
- R11: Valid samples that arrive while no frame is open are ignored and produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | SAMPLE_W | Incoming sample, most significant bit first in time |
| in_sof | input | 1 | First sample of a frame (qualified by in_valid) |
| in_eof | input | 1 | Last sample of a frame (qualified by in_valid) |
| in_valid | input | 1 | Input sample is present |
| out_data | output | SAMPLE_W | Emitted message sample |
| out_sof | output | 1 | First emitted sample of the frame |
| out_eof | output | 1 | Last message sample of the frame |
| out_valid | output | 1 | Output sample is present |
| out_err | output | 1 | Checksum mismatch verdict, valid with out_eof |

## Verification
The checksum path is tried with several patterns:
- The classic nine-byte ASCII vector with its known checksum.
- The same frame with a checksum that differs in one bit.
- A longer pseudo-random payload sent with idle gaps, with a correct checksum and also with one flipped message bit.
- A one-byte message.

The first two separate a correct bit order and polynomial from near misses. The gapped frames show that idle cycles do not disturb the remainder. The flipped message bit shows that corruption in the payload is caught, and not only corruption in the checksum bytes.

The framing paths are tried with several more cases:
- Frames of only two samples or one sample.
- Stray samples outside any frame.
- A frame abandoned by a new start strobe.
- Back-to-back frames.

These show the window, the output strobes and the reseeding behave correctly.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } chk_state_e;

endpackage

// File: rtl/crc_chk_update.sv
module crc_chk_update #(
    parameter int          CRC_W       = 16,
    parameter int          SAMPLE_W    = 8,
    parameter logic [CRC_W:0] GEN_POLY = 17'h11021,
    parameter bit          DIRECT_MODE = 1'b1,
    parameter bit          FLIP_IN     = 1'b0
) (
    input  logic [CRC_W-1:0]    state_i,
    input  logic [SAMPLE_W-1:0] data_i,
    output logic [CRC_W-1:0]    state_o
);
    localparam logic [CRC_W-1:0] TAPS = GEN_POLY[CRC_W-1:0];
    localparam int               NBYTES = SAMPLE_W / 8;

    logic [SAMPLE_W-1:0] feed;

    // optional per-byte bit reversal ahead of the remainder
    generate
        if (FLIP_IN) begin : g_flip
            for (genvar g = 0; g < NBYTES; g++) begin : g_byte
                for (genvar k = 0; k < 8; k++) begin : g_bit
                    assign feed[g*8 + k] = data_i[g*8 + 7 - k];
                end
            end
        end else begin : g_pass
            assign feed = data_i;
        end
    endgenerate

    // SAMPLE_W bit steps unrolled: equals the F^W * X xor D form
    always_comb begin
        logic [CRC_W-1:0] x;
        logic             fb;
        x = state_i;
        for (int b = SAMPLE_W - 1; b >= 0; b--) begin
            if (DIRECT_MODE) begin
                fb = x[CRC_W-1] ^ feed[b];
                x  = {x[CRC_W-2:0], 1'b0};
            end else begin
                fb = x[CRC_W-1];
                x  = {x[CRC_W-2:0], feed[b]};
            end
            if (fb) begin
                x = x ^ TAPS;
            end
        end
        state_o = x;
    end

endmodule

// File: rtl/crc_chk_final.sv
module crc_chk_final #(
    parameter int             CRC_W       = 16,
    parameter logic [CRC_W:0] GEN_POLY    = 17'h11021,
    parameter bit             DIRECT_MODE = 1'b1,
    parameter bit             FLIP_CRC    = 1'b0,
    parameter logic [CRC_W-1:0] XOR_OUT   = '0
) (
    input  logic [CRC_W-1:0] state_i,
    output logic [CRC_W-1:0] crc_o
);
    localparam logic [CRC_W-1:0] TAPS   = GEN_POLY[CRC_W-1:0];
    localparam int               NBYTES = CRC_W / 8;

    logic [CRC_W-1:0] flushed;
    logic [CRC_W-1:0] ordered;

    // nondirect form needs CRC_W zero bits pushed through to finish
    generate
        if (DIRECT_MODE) begin : g_direct
            assign flushed = state_i;
        end else begin : g_augment
            always_comb begin
                logic [CRC_W-1:0] x;
                logic             fb;
                x = state_i;
                for (int b = 0; b < CRC_W; b++) begin
                    fb = x[CRC_W-1];
                    x  = {x[CRC_W-2:0], 1'b0};
                    if (fb) begin
                        x = x ^ TAPS;
                    end
                end
                flushed = x;
            end
        end
    endgenerate

    generate
        if (FLIP_CRC) begin : g_flip
            for (genvar g = 0; g < NBYTES; g++) begin : g_byte
                for (genvar k = 0; k < 8; k++) begin : g_bit
                    assign ordered[g*8 + k] = flushed[g*8 + 7 - k];
                end
            end
        end else begin : g_pass
            assign ordered = flushed;
        end
    endgenerate

    assign crc_o = ordered ^ XOR_OUT;

endmodule

// File: rtl/crc_chk_window.sv
module crc_chk_window #(
    parameter int SAMPLE_W = 8,
    parameter int DEPTH    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_i,
    input  logic [SAMPLE_W-1:0]       data_i,
    output logic [SAMPLE_W-1:0]       oldest_o,
    output logic [DEPTH*SAMPLE_W-1:0] tail_o
);
    logic [SAMPLE_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else if (push_i) begin
            slot_q[0] <= data_i;
            for (int i = 1; i < DEPTH; i++) begin
                slot_q[i] <= slot_q[i-1];
            end
        end
    end

    assign oldest_o = slot_q[DEPTH-1];

    // last DEPTH samples including the one arriving now, oldest on top
    generate
        if (DEPTH == 1) begin : g_single
            assign tail_o = data_i;
        end else begin : g_multi
            assign tail_o[SAMPLE_W-1:0] = data_i;
            for (genvar j = 0; j < DEPTH - 1; j++) begin : g_slot
                assign tail_o[(j+1)*SAMPLE_W +: SAMPLE_W] = slot_q[j];
            end
        end
    endgenerate

endmodule

// File: rtl/crc_frame_checker.sv
module crc_frame_checker
    import crc_chk_pkg::*;
#(
    parameter int               CRC_W       = 16,
    parameter int               SAMPLE_W    = 8,
    parameter logic [CRC_W:0]   GEN_POLY    = 17'h11021,
    parameter logic [CRC_W-1:0] SEED        = 16'hFFFF,
    parameter bit               DIRECT_MODE = 1'b1,
    parameter bit               FLIP_IN     = 1'b0,
    parameter bit               FLIP_CRC    = 1'b0,
    parameter logic [CRC_W-1:0] XOR_OUT     = 16'h0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_sof,
    input  logic                in_eof,
    input  logic                in_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_sof,
    output logic                out_eof,
    output logic                out_valid,
    output logic                out_err
);
    localparam int K     = CRC_W / SAMPLE_W;
    localparam int CNT_W = $clog2(K + 1);

    chk_state_e          state_q, state_d, restart_to;
    logic [CNT_W-1:0]    fill_q;
    logic [CRC_W-1:0]    crc_q;
    logic                first_q;

    logic                start;
    logic                push;
    logic                pop;
    logic [SAMPLE_W-1:0] oldest;
    logic [CRC_W-1:0]    rx_fcs;
    logic [CRC_W-1:0]    crc_upd;
    logic [CRC_W-1:0]    crc_fin;

    assign start = in_valid && in_sof;
    assign push  = start || (in_valid && (state_q != ST_IDLE));
    assign pop   = in_valid && !in_sof && (state_q == ST_RUN);

    crc_chk_window #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (K)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push),
        .data_i   (in_data),
        .oldest_o (oldest),
        .tail_o   (rx_fcs)
    );

    crc_chk_update #(
        .CRC_W       (CRC_W),
        .SAMPLE_W    (SAMPLE_W),
        .GEN_POLY    (GEN_POLY),
        .DIRECT_MODE (DIRECT_MODE),
        .FLIP_IN     (FLIP_IN)
    ) u_update (
        .state_i (crc_q),
        .data_i  (oldest),
        .state_o (crc_upd)
    );

    crc_chk_final #(
        .CRC_W       (CRC_W),
        .GEN_POLY    (GEN_POLY),
        .DIRECT_MODE (DIRECT_MODE),
        .FLIP_CRC    (FLIP_CRC),
        .XOR_OUT     (XOR_OUT)
    ) u_final (
        .state_i (crc_upd),
        .crc_o   (crc_fin)
    );

    // where a start strobe leads: a one-sample frame is dropped at once
    always_comb begin
        if (in_eof) begin
            restart_to = ST_IDLE;
        end else if (K == 1) begin
            restart_to = ST_RUN;
        end else begin
            restart_to = ST_FILL;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = restart_to;
            end
            ST_FILL: begin
                if (start) begin
                    state_d = restart_to;
                end else if (in_valid) begin
                    if (in_eof) begin
                        state_d = ST_IDLE;
                    end else if (fill_q == CNT_W'(K - 1)) begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (start) begin
                    state_d = restart_to;
                end else if (in_valid && in_eof) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fill_q  <= '0;
            crc_q   <= SEED;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                fill_q  <= CNT_W'(1);
                crc_q   <= SEED;
                first_q <= 1'b1;
            end else begin
                if (in_valid && (state_q == ST_FILL)) begin
                    fill_q <= fill_q + CNT_W'(1);
                end
                if (pop) begin
                    crc_q   <= crc_upd;
                    first_q <= 1'b0;
                end
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= pop;
            out_data  <= oldest;
            out_sof   <= pop && first_q;
            out_eof   <= pop && in_eof;
            out_err   <= pop && in_eof && (crc_fin != rx_fcs);
        end
    end

endmodule

// File: rtl/crc_frame_checker_sva.sv
module crc_frame_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sof,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic out_err
);
    assert_err_with_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_eof);

    assert_sof_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    assert_eof_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_valid);

    assert_idle_no_emit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_restart_no_emit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> !out_valid);

    assert_gap_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !out_valid);

endmodule

bind crc_frame_checker crc_frame_checker_sva u_sva (.*);

// File: tb/tb_crc_frame_checker.sv
module tb_crc_frame_checker;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] data;
        logic       sof;
        logic       eof;
        logic       err;
        string      req;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] out_data;
    logic       out_sof, out_eof, out_valid, out_err;

    int n_checks = 0;
    int n_fails  = 0;
    exp_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_frame_checker #(
        .CRC_W(16), .SAMPLE_W(8), .GEN_POLY(17'h11021), .SEED(16'hFFFF),
        .DIRECT_MODE(1'b1), .FLIP_IN(1'b0), .FLIP_CRC(1'b0), .XOR_OUT(16'h0000)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_valid(in_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_valid(out_valid), .out_err(out_err)
    );

    function automatic logic [15:0] ref_crc(input logic [7:0] m[$]);
        logic [15:0] c = 16'hFFFF;
        logic        fb;
        foreach (m[i]) begin
            for (int b = 7; b >= 0; b--) begin
                fb = c[15] ^ m[i][b];
                c  = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s", req, what);
        end
    endtask

    task automatic expect_item(input logic [7:0] d, input logic s, input logic e,
                               input logic er, input string req);
        exp_item_t it;
        it.data = d; it.sof = s; it.eof = e; it.err = er; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic drive(input logic [7:0] d, input logic s, input logic e);
        @(posedge clk);
        #1;
        in_data = d; in_sof = s; in_eof = e; in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
    endtask

    // message plus two checksum bytes, expected output queued first
    task automatic send_frame(input logic [7:0] msg[$], input logic [15:0] fcs,
                              input int gap, input string req);
        logic [7:0] all[$];
        logic       bad;
        bad = (fcs != ref_crc(msg));
        foreach (msg[i])
            expect_item(msg[i], i == 0, i == msg.size() - 1,
                        (i == msg.size() - 1) ? bad : 1'b0, req);
        all = msg;
        all.push_back(fcs[15:8]);
        all.push_back(fcs[7:0]);
        foreach (all[i]) begin
            drive(all[i], i == 0, i == all.size() - 1);
            if (gap > 0 && (i % 2 == 1) && i != all.size() - 1) idle(gap);
        end
    endtask

    // monitor: compare every emitted sample with the queue head
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 R9 R11",
                      $sformatf("unexpected output data=%h sof=%b eof=%b expected none",
                                out_data, out_sof, out_eof));
            end else begin
                exp_item_t e;
                e = exp_q.pop_front();
                check(out_data == e.data && out_sof == e.sof && out_eof == e.eof
                      && out_err == e.err, e.req,
                      $sformatf("got data=%h sof=%b eof=%b err=%b expected data=%h sof=%b eof=%b err=%b",
                                out_data, out_sof, out_eof, out_err,
                                e.data, e.sof, e.eof, e.err));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] ascii[$];
        logic [7:0] longm[$];
        logic [7:0] flipped[$];
        logic [7:0] one[$];
        logic [7:0] other[$];

        ascii = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        for (int i = 0; i < 20; i++) longm.push_back(8'(i * 37 + 5));
        one   = '{8'hA5};
        other = '{8'h10, 8'h20, 8'h30, 8'h40};

        repeat (3) @(negedge clk);
        check(!out_valid && !out_sof && !out_eof && !out_err, "R1",
              $sformatf("in reset outputs=%b%b%b%b expected 0000",
                        out_valid, out_sof, out_eof, out_err));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !out_sof && !out_eof && !out_err, "R1",
              $sformatf("after reset outputs=%b%b%b%b expected 0000",
                        out_valid, out_sof, out_eof, out_err));

        // R5 known vector, R2 R4 framing
        send_frame(ascii, 16'h29B1, 0, "R5 R2 R4 good");
        idle(3);
        // R5 checksum one bit off
        send_frame(ascii, 16'h29B0, 0, "R5 bad fcs");
        idle(2);
        // R7 gaps, correct then a corrupted message bit
        send_frame(longm, ref_crc(longm), 2, "R7 R5 gapped good");
        idle(2);
        flipped = longm;
        flipped[7] = flipped[7] ^ 8'h10;
        expect_item(8'h00, 1'b0, 1'b0, 1'b0, "dummy");
        void'(exp_q.pop_back());
        foreach (flipped[i])
            expect_item(flipped[i], i == 0, i == flipped.size() - 1,
                        i == flipped.size() - 1, "R5 R7 corrupted payload");
        begin
            logic [15:0] f = ref_crc(longm);
            foreach (flipped[i]) begin
                drive(flipped[i], i == 0, 1'b0);
                if (i % 3 == 0) idle(1);
            end
            drive(f[15:8], 1'b0, 1'b0);
            drive(f[7:0], 1'b0, 1'b1);
        end
        idle(2);

        // R9 two-sample and one-sample frames
        drive(8'h29, 1'b1, 1'b0);
        drive(8'hB1, 1'b0, 1'b1);
        idle(2);
        drive(8'h77, 1'b1, 1'b1);
        idle(2);
        // R11 stray samples outside a frame
        drive(8'h01, 1'b0, 1'b0);
        drive(8'h02, 1'b0, 1'b0);
        drive(8'h03, 1'b0, 1'b1);
        idle(3);
        check(exp_q.size() == 0, "R9 R11",
              $sformatf("pending=%0d expected 0", exp_q.size()));

        // R8 abandoned frame: 5 samples emit 3, no eof, then reseeded frame
        expect_item(8'hC0, 1'b1, 1'b0, 1'b0, "R8 abandoned");
        expect_item(8'hC1, 1'b0, 1'b0, 1'b0, "R8 abandoned");
        expect_item(8'hC2, 1'b0, 1'b0, 1'b0, "R8 abandoned");
        for (int i = 0; i < 5; i++) drive(8'(8'hC0 + i), i == 0, 1'b0);
        send_frame(ascii, 16'h29B1, 0, "R8 restart good");
        idle(2);

        // one-byte message: sof and eof together, good then bad
        send_frame(one, ref_crc(one), 0, "R4 R3 one-byte good");
        send_frame(one, ref_crc(one) ^ 16'h8000, 0, "R4 R3 one-byte bad");
        // back to back
        send_frame(other, ref_crc(other), 0, "R2 back-to-back");
        send_frame(ascii, 16'h29B1, 0, "R2 back-to-back");
        idle(4);
        // stray samples after a frame end
        drive(8'h55, 1'b0, 1'b0);
        drive(8'h66, 1'b0, 1'b0);
        idle(4);

        check(exp_q.size() == 0, "R3 R11",
              $sformatf("pending=%0d expected 0", exp_q.size()));
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule